// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block holds six 32-bit performance counters and two control registers that decide what each counter counts. Every clock it receives the number of instructions retired in that cycle and a run-latch flag. Counters 1 to 4 each take an 8-bit event selector from control register 1 and decode it into one of three modes: count retired instructions, count clock cycles, or stay idle. Counter 5 always counts instructions and counter 6 always counts cycles. Freeze bits in control register 0 can stop all counters, or one of the two groups.

When a counting counter reaches the sign-bit value 0x80000000 and its overflow enable is set, the counter is clamped to exactly that value and an alert is raised. The alert can set the global freeze bit. It can also turn the alert-enable bit into a latched alert-occurred bit, which drives the interrupt line. Software reads and writes both control registers and every counter through a simple address/data register port.

Top module: `pmon_bank`

## Requirements
- R1: While control register 0 bit 0 (global freeze) is 1, no counter changes except by a software write, whatever the selectors hold.
- R2: Counters 1 to 4 count only while control register 0 bit 1 is 0 and control register 1 is nonzero. Counters 5 and 6 count only while control register 0 bit 2 is 0.
- R3: Counter 1 selector (control register 1 bits 31:24): codes 0x02 and 0xFE add the retired count each clock, and codes 0x1E and 0xF0 add one each clock.
- R4: Counters 2 and 3 (selector bits 23:16 and 15:8) count instructions for code 0x02 and cycles for code 0x1E. Any other code leaves them idle, and this includes 0xF0 and 0xFE.
- R5: Counter 4 (selector bits 7:0) counts instructions for code 0x02, and also for code 0xFA while run_latch is 1. It counts cycles for code 0x1E. Code 0xFA with run_latch at 0 leaves it idle.
- R6: Counter 5 adds the retired count each clock, and counter 6 adds one each clock, while they are not frozen.
- R7: If a counting counter's new value would be 0x80000000 or above and its overflow enable is set, the counter becomes exactly 0x80000000 and an alert is raised. Counter 1 uses control register 0 bit 3 as its enable, and counters 2 to 6 share bit 4. When the enable is clear, the counter passes the threshold and wraps modulo 2^32.
- R8: On an alert (one per clock, however many counters overflow), bit 5 set causes bit 0 to be set. If bit 6 is set, bit 6 is cleared and bit 7 is set. A software write to control register 0 in the same clock takes priority.
- R9: The irq output equals control register 0 bit 7 at all times, including after software writes that bit.
- R10: A counter write keeps the low 32 bits of reg_wdata and takes priority over counting in that clock.
- R11: Register map: address 0 is control register 0 (8 bits, read zero-extended), address 1 is control register 1, and addresses 2 to 7 are counters 1 to 6. Reads are combinational. Reset clears every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 64 | Write data; counters keep the low 32 bits |
| reg_rdata | output | 32 | Read data for reg_addr |
| retire_cnt | input | 4 | Instructions retired this clock |
| run_latch | input | 1 | Run-latch flag used by counter 4 code 0xFA |
| irq | output | 1 | Performance-monitor interrupt |

## Verification
The bench targets decode boundaries first. It checks that 0xF0 and 0xFE are accepted only by counter 1, and that 0xFA counts only while run_latch is high; a shared decode would make counters 2 to 4 count on these codes. For overflow, it drives a counter from just below the threshold with a multi-instruction step, so that an overflow check written as an equality test, or a missing clamp, leaves 0x80000001. It also confirms that the shared enable does not cover counter 1 and that a disabled counter wraps. The alert tests read back the exact control register 0 pattern after freeze-on-alert, after alert-to-occurred conversion, and after several counters overflow at once, and they check that a write in the same clock as counting wins.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
  localparam int N_CTR = 6;
  localparam int N_SEL = 4;
  localparam int SEL_W = 8;
  localparam int CTL0_W = 8;

  // control register 0 bit positions
  localparam int B_FRZ_ALL = 0;
  localparam int B_FRZ_14  = 1;
  localparam int B_FRZ_56  = 2;
  localparam int B_OVE_1   = 3;
  localparam int B_OVE_J   = 4;
  localparam int B_FRZ_ON  = 5;
  localparam int B_ALR_EN  = 6;
  localparam int B_ALR_HIT = 7;

  // event codes
  localparam logic [SEL_W-1:0] EV_INS     = 8'h02;
  localparam logic [SEL_W-1:0] EV_CYC     = 8'h1E;
  localparam logic [SEL_W-1:0] EV_INS_C1  = 8'hFE;
  localparam logic [SEL_W-1:0] EV_CYC_C1  = 8'hF0;
  localparam logic [SEL_W-1:0] EV_RUN_C4  = 8'hFA;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_INS  = 2'd1,
    MODE_CYC  = 2'd2
  } ctr_mode_e;
endpackage

// File: rtl/pmon_event_decode.sv
module pmon_event_decode
  import pmon_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             run_latch,
  input  logic             frz_all,
  input  logic             frz_14,
  input  logic             frz_56,
  input  logic             ctl1_nz,
  output ctr_mode_e        mode
);
  generate
    if (IDX < N_SEL) begin : g_sel
      logic ins_hit, cyc_hit;
      always_comb begin
        ins_hit = (sel == EV_INS);
        cyc_hit = (sel == EV_CYC);
        if (IDX == 0) begin
          ins_hit = ins_hit | (sel == EV_INS_C1);
          cyc_hit = cyc_hit | (sel == EV_CYC_C1);
        end
        if (IDX == 3) ins_hit = ins_hit | ((sel == EV_RUN_C4) & run_latch);
      end
      always_comb begin
        mode = MODE_IDLE;
        if (!frz_all && !frz_14 && ctl1_nz) begin
          if (ins_hit)      mode = MODE_INS;
          else if (cyc_hit) mode = MODE_CYC;
        end
      end
    end else begin : g_fixed
      logic unused_sel;
      assign unused_sel = ^{sel, run_latch, frz_14, ctl1_nz};
      always_comb begin
        mode = MODE_IDLE;
        if (!frz_all && !frz_56) mode = (IDX == N_SEL) ? MODE_INS : MODE_CYC;
      end
    end
  endgenerate
endmodule

// File: rtl/pmon_counter.sv
module pmon_counter
  import pmon_pkg::*;
#(
  parameter int CTR_W = 32,
  parameter int RET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_mode_e        mode,
  input  logic [RET_W-1:0] retire,
  input  logic             ovf_en,
  input  logic             wr_en,
  input  logic [CTR_W-1:0] wr_val,
  output logic [CTR_W-1:0] cnt,
  output logic             ovf
);
  localparam int SUM_W = CTR_W + 1;
  localparam logic [SUM_W-1:0] THR_X = SUM_W'(1) << (CTR_W - 1);
  localparam logic [CTR_W-1:0] THR   = THR_X[CTR_W-1:0];

  logic [CTR_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] inc, sum;
  logic             active, hit, cnt_en;

  always_comb begin
    active = (mode != MODE_IDLE);
    inc    = '0;
    if (mode == MODE_INS)      inc = SUM_W'(retire);
    else if (mode == MODE_CYC) inc = SUM_W'(1);
    sum    = {1'b0, cnt_q} + inc;
    hit    = active && ovf_en && (sum >= THR_X);
    cnt_en = wr_en | active;
    if (wr_en)    cnt_d = wr_val;
    else if (hit) cnt_d = THR;
    else          cnt_d = sum[CTR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
  assign ovf = hit & ~wr_en;

  p_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == THR));
  p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_val)));
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_IDLE && !wr_en) |=> $stable(cnt));
endmodule

// File: rtl/pmon_ctrl.sv
module pmon_ctrl
  import pmon_pkg::*;
#(
  parameter int CTL1_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl0_we,
  input  logic              ctl1_we,
  input  logic [CTL1_W-1:0] wdata,
  input  logic              alert,
  output logic [CTL0_W-1:0] ctl0,
  output logic [CTL1_W-1:0] ctl1
);
  logic [CTL0_W-1:0] ctl0_q, ctl0_d;
  logic [CTL1_W-1:0] ctl1_q;
  logic              ctl0_en;

  always_comb begin
    ctl0_d  = ctl0_q;
    ctl0_en = ctl0_we | alert;
    if (ctl0_we) begin
      ctl0_d = wdata[CTL0_W-1:0];
    end else if (alert) begin
      if (ctl0_q[B_FRZ_ON]) ctl0_d[B_FRZ_ALL] = 1'b1;
      if (ctl0_q[B_ALR_EN]) begin
        ctl0_d[B_ALR_EN]  = 1'b0;
        ctl0_d[B_ALR_HIT] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl0_q <= '0;
    else if (ctl0_en) ctl0_q <= ctl0_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctl1_q <= '0;
    else if (ctl1_we) ctl1_q <= wdata;
  end

  assign ctl0 = ctl0_q;
  assign ctl1 = ctl1_q;

  p_alert_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && !ctl0_we && ctl0[B_ALR_EN]) |=> (ctl0[B_ALR_HIT] && !ctl0[B_ALR_EN]));
  p_alert_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alert && !ctl0_we && ctl0[B_FRZ_ON]) |=> ctl0[B_FRZ_ALL]);
endmodule

// File: rtl/pmon_bank.sv
module pmon_bank
  import pmon_pkg::*;
#(
  parameter int CTR_W = 32,
  parameter int RET_W = 4,
  parameter int WD_W  = 64,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [WD_W-1:0]  reg_wdata,
  output logic [CTR_W-1:0] reg_rdata,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic             run_latch,
  output logic             irq
);
  localparam int CTL1_W  = N_SEL * SEL_W;
  localparam int CTR_ORG = 2;

  logic [CTL0_W-1:0]             ctl0;
  logic [CTL1_W-1:0]             ctl1;
  logic [N_CTR-1:0][CTR_W-1:0]   cnt_all;
  logic [N_CTR-1:0]              ovf_vec;
  logic [N_CTR-1:0]              ctr_we;
  logic                          alert;
  logic                          unused_hi;

  assign unused_hi = ^reg_wdata[WD_W-1:CTR_W];
  assign alert     = |ovf_vec;

  pmon_ctrl #(.CTL1_W(CTL1_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl0_we (reg_we && reg_addr == AW'(0)),
    .ctl1_we (reg_we && reg_addr == AW'(1)),
    .wdata   (reg_wdata[CTL1_W-1:0]),
    .alert   (alert),
    .ctl0    (ctl0),
    .ctl1    (ctl1)
  );

  generate
    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
      logic [SEL_W-1:0] sel;
      ctr_mode_e        mode;
      if (i < N_SEL) begin : g_s
        assign sel = ctl1[CTL1_W-1-SEL_W*i -: SEL_W];
      end else begin : g_n
        assign sel = '0;
      end
      assign ctr_we[i] = reg_we && (reg_addr == AW'(i + CTR_ORG));

      pmon_event_decode #(.IDX(i)) u_dec (
        .sel       (sel),
        .run_latch (run_latch),
        .frz_all   (ctl0[B_FRZ_ALL]),
        .frz_14    (ctl0[B_FRZ_14]),
        .frz_56    (ctl0[B_FRZ_56]),
        .ctl1_nz   (|ctl1),
        .mode      (mode)
      );

      pmon_counter #(.CTR_W(CTR_W), .RET_W(RET_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .retire (retire_cnt),
        .ovf_en ((i == 0) ? ctl0[B_OVE_1] : ctl0[B_OVE_J]),
        .wr_en  (ctr_we[i]),
        .wr_val (reg_wdata[CTR_W-1:0]),
        .cnt    (cnt_all[i]),
        .ovf    (ovf_vec[i])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(0)) reg_rdata = CTR_W'(ctl0);
    else if (reg_addr == AW'(1)) reg_rdata = CTR_W'(ctl1);
    for (int k = 0; k < N_CTR; k++) begin
      if (reg_addr == AW'(k + CTR_ORG)) reg_rdata = cnt_all[k];
    end
  end

  assign irq = ctl0[B_ALR_HIT];

  p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl0[B_FRZ_ALL] && ctr_we == '0) |=> $stable(cnt_all));
endmodule

// File: tb/sim_pmon_bank.sv
module sim_pmon_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [63:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  retire_cnt;
  logic        run_latch;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  typedef struct {
    int          kind;   // 0..7 register address, 8 = irq pin
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  event  sample_ev;

  always #10 clk = ~clk;  // 50 MHz

  pmon_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .retire_cnt(retire_cnt),
    .run_latch(run_latch), .irq(irq)
  );

  // monitor: pops expected items and compares against the design
  always @(sample_ev) begin
    item_t       it;
    logic [31:0] act;
    it  = q.pop_front();
    act = (it.kind == 8) ? {31'b0, irq} : reg_rdata;
    n_chk++;
    if (act !== it.exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
    end
  end

  // driver side: push expectation and request a sample
  task automatic chk(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    if (kind < 8) reg_addr = kind[2:0];
    q.push_back(it);
    #1 -> sample_ev;
    #1;
  endtask

  task automatic sync();
    @(negedge clk);
  endtask

  // call in the low clock phase; write lands at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clr();
    for (int k = 2; k < 8; k++) wr(k[2:0], 64'd0);
  endtask

  // n counting clock edges, then frozen again
  task automatic run(input int n, input logic [7:0] unf, input logic [7:0] frz);
    wr(3'd0, {56'd0, unf});
    repeat (n - 1) @(negedge clk);
    wr(3'd0, {56'd0, frz});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    retire_cnt = '0; run_latch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(0, 32'h0, "R11 ctl0 reset");
    chk(1, 32'h0, "R11 ctl1 reset");
    chk(8, 32'h0, "R9 irq reset");
    chk(2, 32'h0, "R11 ctr1 reset");
    sync();
    wr(3'd0, 64'h01);
    clr();

    // R1: global freeze holds everything
    wr(3'd1, 64'h02020202);
    retire_cnt = 4'd3;
    repeat (5) @(negedge clk);
    chk(2, 32'd0, "R1 ctr1 frozen");
    chk(6, 32'd0, "R1 ctr5 frozen");
    chk(7, 32'd0, "R1 ctr6 frozen");
    chk(1, 32'h02020202, "R11 ctl1 readback");

    // instruction code 0x02 on all selectors
    sync();
    run(4, 8'h00, 8'h01);
    chk(2, 32'd12, "R3 ctr1 ins");
    chk(3, 32'd12, "R4 ctr2 ins");
    chk(4, 32'd12, "R4 ctr3 ins");
    chk(5, 32'd12, "R5 ctr4 ins");
    chk(6, 32'd12, "R6 ctr5 ins");
    chk(7, 32'd4,  "R6 ctr6 cyc");

    // cycle code 0x1E
    sync(); clr();
    wr(3'd1, 64'h1E1E1E1E);
    run(5, 8'h00, 8'h01);
    chk(2, 32'd5,  "R3 ctr1 cyc");
    chk(3, 32'd5,  "R4 ctr2 cyc");
    chk(5, 32'd5,  "R5 ctr4 cyc");
    chk(6, 32'd15, "R6 ctr5 ins");

    // counter-1-only codes and run latch low
    sync(); clr();
    wr(3'd1, 64'hFEF055FA);
    retire_cnt = 4'd2; run_latch = 1'b0;
    run(4, 8'h00, 8'h01);
    chk(2, 32'd8, "R3 ctr1 code FE");
    chk(3, 32'd0, "R4 ctr2 code F0 idle");
    chk(4, 32'd0, "R4 ctr3 code 55 idle");
    chk(5, 32'd0, "R5 ctr4 FA latch low");

    sync(); clr();
    wr(3'd1, 64'hF01E02FA);
    run_latch = 1'b1;
    run(3, 8'h00, 8'h01);
    chk(2, 32'd3, "R3 ctr1 code F0");
    chk(3, 32'd3, "R4 ctr2 cyc");
    chk(4, 32'd6, "R4 ctr3 ins");
    chk(5, 32'd6, "R5 ctr4 FA latch high");

    // R2: group freezes
    sync(); clr();
    wr(3'd1, 64'h02020202);
    retire_cnt = 4'd1;
    run(3, 8'h02, 8'h03);
    chk(2, 32'd0, "R2 ctr1 frz14");
    chk(5, 32'd0, "R2 ctr4 frz14");
    chk(6, 32'd3, "R2 ctr5 runs");
    chk(7, 32'd3, "R2 ctr6 runs");
    sync(); clr();
    run(3, 8'h04, 8'h05);
    chk(2, 32'd3, "R2 ctr1 runs");
    chk(6, 32'd0, "R2 ctr5 frz56");
    chk(7, 32'd0, "R2 ctr6 frz56");
    sync(); clr();
    wr(3'd1, 64'h0);
    run(2, 8'h00, 8'h01);
    chk(2, 32'd0, "R2 ctr1 ctl1 zero");
    chk(6, 32'd2, "R2 ctr5 ctl1 zero");

    // R7: clamp, enable split, wrap
    sync(); clr();
    retire_cnt = 4'd3;
    wr(3'd2, 64'h7FFFFFFE);
    wr(3'd1, 64'h02000000);
    run(1, 8'h08, 8'h09);
    chk(2, 32'h80000000, "R7 ctr1 clamp");
    chk(0, 32'h09, "R8 no alert effects");
    chk(8, 32'h0, "R9 irq low");
    sync();
    wr(3'd3, 64'h7FFFFFFE);
    wr(3'd1, 64'h00020000);
    run(1, 8'h08, 8'h09);
    chk(3, 32'h80000001, "R7 ctr2 not clamped by own-enable");
    sync();
    wr(3'd4, 64'h7FFFFFFE);
    wr(3'd1, 64'h00000200);
    run(1, 8'h10, 8'h11);
    chk(4, 32'h80000000, "R7 ctr3 shared enable");
    sync();
    wr(3'd4, 64'hFFFFFFFF);
    run(1, 8'h00, 8'h01);
    chk(4, 32'd2, "R7 wrap");

    // R8: freeze on alert plus alert latch
    sync(); clr();
    wr(3'd1, 64'h0);
    retire_cnt = 4'd1;
    wr(3'd6, 64'h7FFFFFFF);
    wr(3'd0, 64'h70);
    repeat (4) @(negedge clk);
    chk(0, 32'hB1, "R8 ctl0 after alert");
    chk(6, 32'h80000000, "R7 ctr5 clamp");
    chk(7, 32'd1, "R8 frozen after one cycle");
    chk(8, 32'h1, "R9 irq high");

    // R9: software controls the occurred bit
    sync();
    wr(3'd0, 64'h01);
    chk(8, 32'h0, "R9 irq cleared by write");
    sync();
    wr(3'd0, 64'h81);
    chk(8, 32'h1, "R9 irq set by write");
    chk(0, 32'h81, "R11 ctl0 readback");
    sync();
    wr(3'd0, 64'h01);

    // R8: two counters overflow together, no freeze
    sync(); clr();
    wr(3'd2, 64'h7FFFFFFF);
    wr(3'd3, 64'h7FFFFFFF);
    wr(3'd1, 64'h1E1E0000);
    wr(3'd0, 64'h58);
    repeat (3) @(negedge clk);
    chk(0, 32'h98, "R8 multi overflow ctl0");
    chk(8, 32'h1, "R9 irq multi");
    chk(2, 32'h80000000, "R7 ctr1 held");
    chk(3, 32'h80000000, "R7 ctr2 held");
    sync();
    wr(3'd0, 64'h01);

    // R8: freeze only, cycle counter overflow
    sync(); clr();
    wr(3'd1, 64'h0);
    retire_cnt = 4'd0;
    wr(3'd7, 64'h7FFFFFFE);
    wr(3'd0, 64'h30);
    repeat (4) @(negedge clk);
    chk(7, 32'h80000000, "R7 ctr6 cyc clamp");
    chk(0, 32'h31, "R8 freeze only");
    chk(8, 32'h0, "R9 irq stays low");

    // R10: truncation and write priority
    sync();
    wr(3'd4, 64'hDEADBEEF12345678);
    chk(4, 32'h12345678, "R10 low 32 bits");
    sync();
    retire_cnt = 4'd2;
    wr(3'd0, 64'h00);
    wr(3'd6, 64'd100);
    wr(3'd0, 64'h01);
    chk(6, 32'd102, "R10 write wins then counts");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule